// File: doc/BRIEF.md
# Buffered Up-Count PWM Generator

This block produces a pulse-width-modulated output from a 16-bit up-counter. An 8-bit prescaler divides the input clock so that the counter advances once every `psc_i + 1` clocks. The counter runs from zero up to the programmed period limit. At that limit it either wraps back to zero (auto-reload) or stops and holds its value (one-shot). Before polarity is applied, the output is high while the count is below the compare value and low from the compare value through the period limit.

The period and compare inputs do not act on the counter directly. They pass through active buffers that take new values on the cycle that ends a period, or on every cycle while the counter is stopped. This allows the waveform to be reprogrammed without glitches. The active buffers are visible as outputs.

The block keeps three sticky flags: period point, compare-up, and counter at all-ones. Each flag is cleared by writing one to its clear bit. A trigger pulse is selected from the period and compare events. Software can also clear the counter, invert the output polarity and drive an output-enable line.

Top module: `pwm_upcount`

## Requirements
- R1: After reset the counter, both active buffers, all flags and the trigger are zero, and the counter is stopped (`running_o` = 0).
- R2: While running, the counter advances by one on the last clock of every group of `psc_i + 1` clocks. While stopped, it holds its value.
- R3: A counter step taken at the active period value is a period event. It sets `period_flag_o`, and in auto-reload mode (`one_shot_i` = 0) it returns the counter to 0. The period length is (period + 1) × (`psc_i` + 1) clocks.
- R4: A counter step taken at the active compare value is a compare-up event, and it sets `cmp_flag_o`. When the active compare value equals the active period value, this flag is never set.
- R5: Writing one to a bit of `flag_clr_i` clears a flag. Bit 0 clears the period flag, bit 1 the compare flag and bit 2 the max-count flag. A flag that is not cleared stays set.
- R6: `max_flag_o` is set by a counter step taken while the count is 0xFFFF.
- R7: A pulse on `cnt_clr_i` makes the counter read 0 in the next cycle and restarts the prescaler.
- R8: While the counter is stopped, `period_i` and `cmp_i` are copied into the active buffers on every clock. While it is running, they are copied only at a period event.
- R9: In one-shot mode a period event clears `running_o`, and the counter holds the period value.
- R10: Before polarity is applied, `pwm_o` is high when the count is below the active compare value and low otherwise. `inv_i` = 1 inverts it. `pwm_oe_o` follows `oe_i`.
- R11: `trig_sel_i` selects the trigger source: 00 = period event, 01 = compare-up event, 10 = either event, 11 = none. `trig_o` is a one-clock pulse in the cycle where the matching flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_set_i | input | 1 | Pulse that starts counting |
| run_clr_i | input | 1 | Pulse that stops counting (takes priority over start) |
| one_shot_i | input | 1 | 1 = one-shot, 0 = auto-reload |
| psc_i | input | 8 | Prescale divisor minus one |
| period_i | input | 16 | Programmed period limit |
| cmp_i | input | 16 | Programmed compare value |
| cnt_clr_i | input | 1 | Software counter clear pulse |
| flag_clr_i | input | 3 | Write-one-to-clear bits for the flags |
| trig_sel_i | input | 2 | Trigger source select |
| inv_i | input | 1 | Output polarity inversion |
| oe_i | input | 1 | Output enable request |
| cnt_o | output | 16 | Current count |
| running_o | output | 1 | Counter running |
| period_act_o | output | 16 | Active period buffer |
| cmp_act_o | output | 16 | Active compare buffer |
| period_flag_o | output | 1 | Period-point flag |
| cmp_flag_o | output | 1 | Compare-up flag |
| max_flag_o | output | 1 | Max-count flag |
| trig_o | output | 1 | Selected trigger pulse |
| pwm_o | output | 1 | PWM waveform after polarity |
| pwm_oe_o | output | 1 | Output-enable (tri-state control) |

## Verification
A start pulse sets `running_o` at the next edge, and the first count step lands on the edge after that. Active buffers, counter clears, flags and the trigger are all registered, so each is due exactly one edge after its cause. `pwm_o` and `pwm_oe_o` are combinational from registered state and from the present inputs. Every stimulus is applied two time units after a rising edge, and every check samples at that same offset after the next edge. Waveform and trigger vectors are measured only over a full steady-state period window, a few periods after start. This makes the high-time and trigger counts independent of where the count started.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    TRIG_PERIOD = 2'b00,
    TRIG_CMP    = 2'b01,
    TRIG_EITHER = 2'b10,
    TRIG_NONE   = 2'b11
  } trig_sel_e;

  localparam int unsigned FLAG_PERIOD = 0;
  localparam int unsigned FLAG_CMP    = 1;
  localparam int unsigned FLAG_MAX    = 2;
  localparam int unsigned NUM_FLAGS   = 3;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pcnt_q;

  assign tick_o = run_i && (pcnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pcnt_q <= '0;
    else if (!run_i || clr_i)  pcnt_q <= '0;
    else if (pcnt_q == div_i)  pcnt_q <= '0;
    else                       pcnt_q <= pcnt_q + PSC_W'(1);
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_set_i,
  input  logic             run_clr_i,
  input  logic             one_shot_i,
  input  logic             cnt_clr_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic [CNT_W-1:0] period_act_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             period_hit_o,
  output logic             cmp_hit_o,
  output logic             max_hit_o
);
  logic [CNT_W-1:0] cnt_q, per_q, cmp_q;
  logic             run_q;

  assign period_hit_o = tick_i && (cnt_q == per_q);
  // compare event is suppressed when it coincides with the period limit
  assign cmp_hit_o    = tick_i && (cnt_q == cmp_q) && (cmp_q != per_q);
  assign max_hit_o    = tick_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
    end else if (run_clr_i) begin
      run_q <= 1'b0;
    end else if (run_set_i) begin
      run_q <= 1'b1;
    end else if (period_hit_o && one_shot_i) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == per_q) begin
        if (!one_shot_i) cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // shadow-to-active transfer: free while stopped, at period edge while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      cmp_q <= '0;
    end else if (!run_q || period_hit_o) begin
      per_q <= period_i;
      cmp_q <= cmp_i;
    end
  end

  assign cnt_o        = cnt_q;
  assign running_o    = run_q;
  assign period_act_o = per_q;
  assign cmp_act_o    = cmp_q;
endmodule

// File: rtl/pwm_events.sv
module pwm_events
  import pwm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] hit_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  input  logic [1:0]           trig_sel_i,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic                 trig_o
);
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 trig_d, trig_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    // hardware set wins over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (hit_i[g])  flag_q[g] <= 1'b1;
      else if (clr_i[g])  flag_q[g] <= 1'b0;
    end
  end

  always_comb begin
    unique case (trig_sel_e'(trig_sel_i))
      TRIG_PERIOD: trig_d = hit_i[FLAG_PERIOD];
      TRIG_CMP:    trig_d = hit_i[FLAG_CMP];
      TRIG_EITHER: trig_d = hit_i[FLAG_PERIOD] | hit_i[FLAG_CMP];
      default:     trig_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_d;
  end

  assign flag_o = flag_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/pwm_output.sv
module pwm_output #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_act_i,
  input  logic             inv_i,
  input  logic             oe_i,
  output logic             pwm_o,
  output logic             pwm_oe_o
);
  logic raw;

  assign raw      = (cnt_i < cmp_act_i);
  assign pwm_o    = raw ^ inv_i;
  assign pwm_oe_o = oe_i;
endmodule

// File: rtl/pwm_upcount.sv
module pwm_upcount
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_set_i,
  input  logic                 run_clr_i,
  input  logic                 one_shot_i,
  input  logic [PSC_W-1:0]     psc_i,
  input  logic [CNT_W-1:0]     period_i,
  input  logic [CNT_W-1:0]     cmp_i,
  input  logic                 cnt_clr_i,
  input  logic [NUM_FLAGS-1:0] flag_clr_i,
  input  logic [1:0]           trig_sel_i,
  input  logic                 inv_i,
  input  logic                 oe_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 running_o,
  output logic [CNT_W-1:0]     period_act_o,
  output logic [CNT_W-1:0]     cmp_act_o,
  output logic                 period_flag_o,
  output logic                 cmp_flag_o,
  output logic                 max_flag_o,
  output logic                 trig_o,
  output logic                 pwm_o,
  output logic                 pwm_oe_o
);
  logic                 tick;
  logic                 per_hit, cmp_hit, max_hit;
  logic [NUM_FLAGS-1:0] hits, flags;

  pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (running_o),
    .clr_i  (cnt_clr_i),
    .div_i  (psc_i),
    .tick_o (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .run_set_i    (run_set_i),
    .run_clr_i    (run_clr_i),
    .one_shot_i   (one_shot_i),
    .cnt_clr_i    (cnt_clr_i),
    .period_i     (period_i),
    .cmp_i        (cmp_i),
    .cnt_o        (cnt_o),
    .running_o    (running_o),
    .period_act_o (period_act_o),
    .cmp_act_o    (cmp_act_o),
    .period_hit_o (per_hit),
    .cmp_hit_o    (cmp_hit),
    .max_hit_o    (max_hit)
  );

  always_comb begin
    hits              = '0;
    hits[FLAG_PERIOD] = per_hit;
    hits[FLAG_CMP]    = cmp_hit;
    hits[FLAG_MAX]    = max_hit;
  end

  pwm_events u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hits),
    .clr_i      (flag_clr_i),
    .trig_sel_i (trig_sel_i),
    .flag_o     (flags),
    .trig_o     (trig_o)
  );

  assign period_flag_o = flags[FLAG_PERIOD];
  assign cmp_flag_o    = flags[FLAG_CMP];
  assign max_flag_o    = flags[FLAG_MAX];

  pwm_output #(.CNT_W(CNT_W)) u_out (
    .cnt_i     (cnt_o),
    .cmp_act_i (cmp_act_o),
    .inv_i     (inv_i),
    .oe_i      (oe_i),
    .pwm_o     (pwm_o),
    .pwm_oe_o  (pwm_oe_o)
  );
endmodule

// File: rtl/pwm_upcount_chk.sv
module pwm_upcount_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_clr_i,
  input logic [CNT_W-1:0] period_i,
  input logic             cnt_clr_i,
  input logic [1:0]       trig_sel_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             running_o,
  input logic [CNT_W-1:0] period_act_o,
  input logic [CNT_W-1:0] cmp_act_o,
  input logic             period_flag_o,
  input logic             cmp_flag_o,
  input logic             trig_o
);
  assert_hold_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !cnt_clr_i) |=> $stable(cnt_o));

  assert_period_needs_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(period_flag_o) |-> $past(running_o));

  assert_cmp_not_at_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_flag_o) |-> $past(cmp_act_o != period_act_o));

  assert_sw_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_o == '0));

  assert_buffer_stopped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |=> (period_act_o == $past(period_i)));

  assert_one_shot_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(running_o) && !$past(run_clr_i) && !$past(cnt_clr_i)) |-> $stable(cnt_o));

  assert_trig_with_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (period_flag_o || cmp_flag_o));

  assert_trig_none_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i == 2'b11) |=> !trig_o);
endmodule

bind pwm_upcount pwm_upcount_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .run_clr_i     (run_clr_i),
  .period_i      (period_i),
  .cnt_clr_i     (cnt_clr_i),
  .trig_sel_i    (trig_sel_i),
  .cnt_o         (cnt_o),
  .running_o     (running_o),
  .period_act_o  (period_act_o),
  .cmp_act_o     (cmp_act_o),
  .period_flag_o (period_flag_o),
  .cmp_flag_o    (cmp_flag_o),
  .trig_o        (trig_o)
);

// File: tb/pwm_upcount_tb_top.sv
`timescale 1ns/1ps
module pwm_upcount_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_set_i = 0, run_clr_i = 0, one_shot_i = 0, cnt_clr_i = 0;
  logic [7:0]  psc_i = 0;
  logic [15:0] period_i = 0, cmp_i = 0;
  logic [2:0]  flag_clr_i = 0;
  logic [1:0]  trig_sel_i = 0;
  logic        inv_i = 0, oe_i = 0;
  logic [15:0] cnt_o, period_act_o, cmp_act_o;
  logic        running_o, period_flag_o, cmp_flag_o, max_flag_o, trig_o, pwm_o, pwm_oe_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  pwm_upcount dut_i (.*);

  typedef struct packed {
    logic [7:0]  psc;
    logic [15:0] per;
    logic [15:0] cmp;
    logic        inv;
    logic [1:0]  sel;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{psc: 8'd0, per: 16'd9, cmp: 16'd4, inv: 1'b0, sel: 2'd0},
    '{psc: 8'd2, per: 16'd7, cmp: 16'd3, inv: 1'b1, sel: 2'd1},
    '{psc: 8'd1, per: 16'd5, cmp: 16'd5, inv: 1'b0, sel: 2'd2},
    '{psc: 8'd0, per: 16'd4, cmp: 16'd7, inv: 1'b0, sel: 2'd1},
    '{psc: 8'd3, per: 16'd3, cmp: 16'd0, inv: 1'b1, sel: 2'd2},
    '{psc: 8'd0, per: 16'd9, cmp: 16'd4, inv: 1'b0, sel: 2'd3}
  };

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #2;
    end
  endtask

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_run_set();
    run_set_i = 1; step(); run_set_i = 0;
  endtask
  task automatic pulse_run_clr();
    run_clr_i = 1; step(); run_clr_i = 0;
  endtask
  task automatic pulse_cnt_clr();
    cnt_clr_i = 1; step(); cnt_clr_i = 0;
  endtask
  task automatic pulse_flag_clr(logic [2:0] m);
    flag_clr_i = m; step(); flag_clr_i = 0;
  endtask

  task automatic setup(logic [7:0] p, logic [15:0] per, logic [15:0] c);
    pulse_run_clr();
    pulse_cnt_clr();
    pulse_flag_clr(3'b111);
    psc_i = p; period_i = per; cmp_i = c;
    step(2);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    check(cnt_o == 0 && running_o == 0, "R1 cnt/run", cnt_o, 0);
    check({period_flag_o, cmp_flag_o, max_flag_o, trig_o} == 0, "R1 flags",
          {period_flag_o, cmp_flag_o, max_flag_o, trig_o}, 0);
    check(pwm_o == 0 && pwm_oe_o == 0, "R1 output", pwm_o, 0);
    rst_ni = 1;
    step();

    // table of waveform vectors (R2 R3 R10 R11)
    foreach (VECS[k]) begin
      int l, raw_hi, exp_hi, exp_tr, hi, tr, pe, ce;
      setup(VECS[k].psc, VECS[k].per, VECS[k].cmp);
      inv_i = VECS[k].inv; trig_sel_i = VECS[k].sel;
      l = (int'(VECS[k].per) + 1) * (int'(VECS[k].psc) + 1);
      raw_hi = (VECS[k].cmp > VECS[k].per ? int'(VECS[k].per) + 1 : int'(VECS[k].cmp))
               * (int'(VECS[k].psc) + 1);
      exp_hi = VECS[k].inv ? l - raw_hi : raw_hi;
      pe = 1;
      ce = (VECS[k].cmp < VECS[k].per) ? 1 : 0;
      case (VECS[k].sel)
        2'd0: exp_tr = pe;
        2'd1: exp_tr = ce;
        2'd2: exp_tr = pe + ce;
        default: exp_tr = 0;
      endcase
      pulse_run_set();
      step(3 * l);
      hi = 0; tr = 0;
      for (int c = 0; c < l; c++) begin
        step();
        hi += int'(pwm_o);
        tr += int'(trig_o);
      end
      check(hi == exp_hi, $sformatf("R10 R2 R3 vec%0d high time", k), hi, exp_hi);
      check(tr == exp_tr, $sformatf("R11 vec%0d trigger count", k), tr, exp_tr);
    end
    inv_i = 0; trig_sel_i = 0;

    // R8 buffers follow inputs while stopped
    setup(0, 9, 4);
    check(period_act_o == 9 && cmp_act_o == 4, "R8 stopped load", period_act_o, 9);
    // R8 buffered while running, transfer at period point
    pulse_run_set();
    step(3);
    period_i = 3;
    step();
    check(period_act_o == 9, "R8 held while running", period_act_o, 9);
    for (int g = 0; g < 20 && cnt_o != 9; g++) step();
    step();
    check(cnt_o == 0 && period_act_o == 3, "R8 R3 reload at period", period_act_o, 3);

    // R2 counter holds while stopped
    pulse_run_clr();
    begin
      logic [15:0] held;
      held = cnt_o;
      step(5);
      check(cnt_o == held, "R2 hold when stopped", cnt_o, held);
    end

    // R4 compare flag set when cmp < period
    setup(0, 5, 2);
    pulse_run_set();
    step(20);
    check(cmp_flag_o == 1, "R4 compare flag set", cmp_flag_o, 1);
    check(max_flag_o == 0, "R6 max flag not set", max_flag_o, 0);
    // R5 write-one-to-clear, only the selected bit
    pulse_run_clr();
    pulse_flag_clr(3'b010);
    check(cmp_flag_o == 0, "R5 compare cleared", cmp_flag_o, 0);
    check(period_flag_o == 1, "R5 period kept", period_flag_o, 1);
    pulse_flag_clr(3'b001);
    check(period_flag_o == 0, "R5 period cleared", period_flag_o, 0);

    // R4 suppressed when compare equals period
    setup(0, 5, 5);
    pulse_run_set();
    step(20);
    check(cmp_flag_o == 0, "R4 compare suppressed", cmp_flag_o, 0);
    check(period_flag_o == 1, "R3 period flag", period_flag_o, 1);

    // R9 one-shot stops and holds period value
    setup(0, 6, 2);
    one_shot_i = 1;
    step();
    pulse_run_set();
    step(20);
    check(running_o == 0, "R9 run cleared", running_o, 0);
    check(cnt_o == 6, "R9 count held", cnt_o, 6);
    one_shot_i = 0;

    // R7 software clear while running
    pulse_cnt_clr();
    pulse_run_set();
    step(4);
    check(cnt_o != 0, "R7 precondition counting", cnt_o, 1);
    pulse_cnt_clr();
    check(cnt_o == 0, "R7 cleared", cnt_o, 0);

    // R10 output enable passthrough
    oe_i = 1;
    step();
    check(pwm_oe_o == 1, "R10 oe", pwm_oe_o, 1);
    oe_i = 0;

    // R6 max-count flag
    setup(0, 16'hFFFF, 16'd100);
    pulse_run_set();
    step(65540);
    check(max_flag_o == 1, "R6 max flag", max_flag_o, 1);
    pulse_run_clr();
    pulse_flag_clr(3'b100);
    check(max_flag_o == 0, "R5 max cleared", max_flag_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule